// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block takes one write step from N processing elements that all address the same memory bank in one cycle. Each element offers a valid bit, a word address and a data word. Elements that name the same address form a collision group. A run-time policy decides what that group leaves in memory: the highest-priority value, a value that every member agrees on, the lowest-index value, a pseudo-randomly chosen value, or a reduction of all the values. At most one write is committed per address, into a small register file.

Writes happen only on cycles where the write-phase input is high. Outside those cycles the register file answers reads. A reported flag shows that the last write phase had a collision. A sticky error records a common-policy disagreement and stays set until it is cleared.

Top module: `cw_resolver`

## Requirements
- R1: After reset every memory word reads 0, and `rd_data`, `conflict` and `common_err` are 0. The random generator then holds 16'hACE1.
- R2: Memory changes only on a clock edge where `wr_phase` is 1. Reads happen only on an edge where `wr_phase` is 0: `rd_data` then takes the word at `rd_addr` and is visible after that edge. On a write-phase edge `rd_data` holds its value.
- R3: A requester whose `req_valid` bit is 0 takes part in no collision group, under every policy, whatever address and data it presents.
- R4: With `policy` = 0 (priority), a collision group stores the data of its member with the highest index.
- R5: With `policy` = 1 (common), a group stores its value only when all members present equal data. On a disagreement the word keeps its old value, and `common_err` is set after that edge. It stays 1 until an edge where `err_clear` is 1 and no new disagreement occurs.
- R6: With `policy` = 2 (arbitrary), a group stores the data of its member with the lowest index.
- R7: With `policy` = 3 (random), a 16-bit register L starts at 16'hACE1. On every write-phase edge it becomes {L[14:0], L[15]^L[13]^L[12]^L[10]}. A group of c members stores the data of its k-th member counted from the lowest index (k from 0), where k = L mod c and L is the value before the edge.
- R8: With `policy` = 4 (combine), a group stores the reduction of all member data, selected by `red_op`: 0 sum, 1 product, 2 unsigned maximum, 3 unsigned minimum, 4 AND, 5 OR, 6 XOR. Sum and product are truncated to the word width.
- R9: `policy` values 5 to 7 commit nothing, and so does `policy` = 4 with `red_op` = 7.
- R10: `conflict` is 1 after a write-phase edge exactly when two or more valid requesters named the same address on that edge. It is 0 after any edge without a write phase.
- R11: Groups at different addresses are committed in the same write phase, each on its own. A group with a single member stores that member's data under every policy of R4 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_phase | input | 1 | High on the write-phase cycle of a step |
| req_valid | input | N | Valid bit per requester |
| req_addr | input | N*AW | Word address per requester, requester i at bits [i*AW +: AW] |
| req_data | input | N*DW | Data word per requester, requester i at bits [i*DW +: DW] |
| policy | input | 3 | Conflict policy code |
| red_op | input | 3 | Reduction operator for the combine policy |
| err_clear | input | 1 | Clears the sticky common-policy error |
| rd_addr | input | AW | Read address, used outside the write phase |
| rd_data | output | DW | Registered read data |
| conflict | output | 1 | Last write phase had a collision |
| common_err | output | 1 | Sticky common-policy disagreement flag |

## Verification
The random policy is the hardest to reach: its outcome depends on a generator that only moves on write phases, so every earlier phase changes which member wins. The bench keeps its own model of the generator and steps it on each write phase it issues, including empty ones. It then repeats one three-member collision over several phases, so that different members are picked. The sticky error also needs a clean agreement phase, then a disagreement, idle cycles and a clear pulse, in that order.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  typedef enum logic [2:0] {
    POL_PRIO   = 3'd0,
    POL_COMMON = 3'd1,
    POL_ARB    = 3'd2,
    POL_RAND   = 3'd3,
    POL_COMB   = 3'd4
  } policy_e;

  typedef enum logic [2:0] {
    RED_SUM  = 3'd0,
    RED_PROD = 3'd1,
    RED_MAX  = 3'd2,
    RED_MIN  = 3'd3,
    RED_AND  = 3'd4,
    RED_OR   = 3'd5,
    RED_XOR  = 3'd6,
    RED_NONE = 3'd7
  } redop_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/cwr_lfsr.sv
module cwr_lfsr
  import cwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [15:0] value
);

  logic feedback;

  always_comb feedback = value[15] ^ value[13] ^ value[12] ^ value[10];

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= LFSR_SEED;
    end else if (step) begin
      value <= {value[14:0], feedback};
    end
  end

endmodule

// File: rtl/cwr_group.sv
module cwr_group
  import cwr_pkg::*;
#(
  parameter int N   = 8,
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int IDX = 0
) (
  input  logic [N-1:0]    req_valid,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_data,
  input  logic [2:0]      policy,
  input  logic [2:0]      red_op,
  input  logic [15:0]     rnd,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            mismatch,
  output logic            shared
);

  localparam int CW = $clog2(N) + 1;

  policy_e        pol;
  redop_e         op;
  logic [AW-1:0]  own_addr;
  logic [DW-1:0]  own_data;
  logic [N-1:0]   member;
  logic [CW-1:0]  count;
  logic           leader;
  logic [CW-1:0]  seen;
  logic [15:0]    kth;
  logic           all_eq;
  logic [DW-1:0]  pri_data;
  logic [DW-1:0]  rnd_data;
  logic [DW-1:0]  acc;
  logic [DW-1:0]  word;

  always_comb begin
    pol      = policy_e'(policy);
    op       = redop_e'(red_op);
    own_addr = req_addr[IDX*AW +: AW];
    own_data = req_data[IDX*DW +: DW];
  end

  // Group membership: every valid requester at this requester's address.
  // The lowest-index member leads the group and issues its write.
  always_comb begin
    member = '0;
    count  = '0;
    leader = req_valid[IDX];
    for (int j = 0; j < N; j++) begin
      member[j] = req_valid[j] && (req_addr[j*AW +: AW] == own_addr);
      if (member[j]) count = count + CW'(1);
      if ((j < IDX) && member[j]) leader = 1'b0;
    end
  end

  // Priority, random and common selection over the members.
  always_comb begin
    pri_data = own_data;
    rnd_data = own_data;
    all_eq   = 1'b1;
    seen     = '0;
    kth      = (count == '0) ? 16'd0 : (rnd % 16'(count));
    for (int j = 0; j < N; j++) begin
      if (member[j]) begin
        pri_data = req_data[j*DW +: DW];
        if (16'(seen) == kth) rnd_data = req_data[j*DW +: DW];
        if (req_data[j*DW +: DW] != own_data) all_eq = 1'b0;
        seen = seen + CW'(1);
      end
    end
  end

  // Combining reduction: the leader is the first member, fold the rest.
  always_comb begin
    acc = own_data;
    for (int j = 0; j < N; j++) begin
      if (member[j] && (j > IDX)) begin
        word = req_data[j*DW +: DW];
        case (op)
          RED_SUM:  acc = acc + word;
          RED_PROD: acc = acc * word;
          RED_MAX:  if (word > acc) acc = word;
          RED_MIN:  if (word < acc) acc = word;
          RED_AND:  acc = acc & word;
          RED_OR:   acc = acc | word;
          RED_XOR:  acc = acc ^ word;
          default:  acc = acc;
        endcase
      end
    end
    word = '0;
  end

  always_comb begin
    wr_addr  = own_addr;
    shared   = leader && (count > CW'(1));
    mismatch = leader && (pol == POL_COMMON) && !all_eq;
    wr_en    = 1'b0;
    wr_data  = own_data;
    case (pol)
      POL_PRIO: begin
        wr_en   = leader;
        wr_data = pri_data;
      end
      POL_COMMON: begin
        wr_en   = leader && all_eq;
        wr_data = own_data;
      end
      POL_ARB: begin
        wr_en   = leader;
        wr_data = own_data;
      end
      POL_RAND: begin
        wr_en   = leader;
        wr_data = rnd_data;
      end
      POL_COMB: begin
        wr_en   = leader && (op != RED_NONE);
        wr_data = acc;
      end
      default: wr_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/cwr_regfile.sv
module cwr_regfile #(
  parameter int N     = 8,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    we,
  input  logic [N*AW-1:0] waddr,
  input  logic [N*DW-1:0] wdata,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data
);

  logic [DW-1:0] mem [DEPTH];

  // Write ports carry distinct addresses: at most one port hits a word.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      rd_data <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        for (int j = 0; j < N; j++) begin
          if (we[j] && (waddr[j*AW +: AW] == AW'(w))) mem[w] <= wdata[j*DW +: DW];
        end
      end
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
  import cwr_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_phase,
  input  logic [N-1:0]    req_valid,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_data,
  input  logic [2:0]      policy,
  input  logic [2:0]      red_op,
  input  logic            err_clear,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            conflict,
  output logic            common_err
);

  localparam int DEPTH = 1 << AW;

  logic [N-1:0]    live_valid;
  logic [15:0]     rnd;
  logic [N-1:0]    grp_we;
  logic [N*AW-1:0] grp_addr;
  logic [N*DW-1:0] grp_data;
  logic [N-1:0]    grp_mis;
  logic [N-1:0]    grp_shared;

  always_comb live_valid = req_valid & {N{wr_phase}};

  cwr_lfsr u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .step  (wr_phase),
    .value (rnd)
  );

  for (genvar g = 0; g < N; g++) begin : g_grp
    cwr_group #(.N(N), .AW(AW), .DW(DW), .IDX(g)) u_grp (
      .req_valid (live_valid),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .policy    (policy),
      .red_op    (red_op),
      .rnd       (rnd),
      .wr_en     (grp_we[g]),
      .wr_addr   (grp_addr[g*AW +: AW]),
      .wr_data   (grp_data[g*DW +: DW]),
      .mismatch  (grp_mis[g]),
      .shared    (grp_shared[g])
    );
  end

  cwr_regfile #(.N(N), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .we      (grp_we),
    .waddr   (grp_addr),
    .wdata   (grp_data),
    .rd_en   (!wr_phase),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict   <= 1'b0;
      common_err <= 1'b0;
    end else begin
      conflict   <= |grp_shared;
      common_err <= (|grp_mis) | (common_err & ~err_clear);
    end
  end

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_phase,
  input logic [N-1:0]    req_valid,
  input logic [N*AW-1:0] req_addr,
  input logic [2:0]      policy,
  input logic            err_clear,
  input logic [DW-1:0]   rd_data,
  input logic            conflict,
  input logic            common_err
);

  logic dup;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (req_valid[i] && req_valid[j] &&
            (req_addr[i*AW +: AW] == req_addr[j*AW +: AW])) dup = 1'b1;
      end
    end
  end

  AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_phase && dup) |=> conflict);                                    // R10
  AST_CONFLICT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(wr_phase && dup) |=> !conflict);                                  // R10
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_phase |=> $stable(rd_data));                                     // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (common_err && !err_clear) |=> common_err);                         // R5
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (err_clear && !wr_phase) |=> !common_err);                          // R5
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(common_err) |-> $past(wr_phase && (policy == 3'd1)));         // R5

endmodule

bind cw_resolver cwr_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_phase   (wr_phase),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .policy     (policy),
  .err_clear  (err_clear),
  .rd_data    (rd_data),
  .conflict   (conflict),
  .common_err (common_err)
);

// File: tb/cw_resolver_test.sv
module cw_resolver_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] DATA_A = {16'h0070, 16'h0060, 16'h0050, 16'h0040,
                                     16'h0030, 16'h0020, 16'h0010, 16'h0005};

  typedef struct packed {
    logic [2:0]  pol;
    logic [2:0]  op;
    logic [7:0]  vld;
    logic [31:0] addr;
    logic [3:0]  ca;
    logic [15:0] ev;
    logic        ec;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 8'b0010_0110, 32'h33333333, 4'h3, 16'h0050, 1'b1, 4'd4},  // R4
    '{3'd2, 3'd0, 8'b0010_0110, 32'h44444444, 4'h4, 16'h0010, 1'b1, 4'd6},  // R6
    '{3'd4, 3'd0, 8'b1000_0011, 32'h55555555, 4'h5, 16'h0085, 1'b1, 4'd8},  // R8 sum
    '{3'd4, 3'd2, 8'b0101_0100, 32'h66666666, 4'h6, 16'h0060, 1'b1, 4'd8},  // R8 max
    '{3'd4, 3'd3, 8'b0101_0100, 32'h77777777, 4'h7, 16'h0020, 1'b1, 4'd8},  // R8 min
    '{3'd4, 3'd1, 8'b0000_0011, 32'h88888888, 4'h8, 16'h0050, 1'b1, 4'd8},  // R8 product
    '{3'd4, 3'd6, 8'b0000_0111, 32'h99999999, 4'h9, 16'h0035, 1'b1, 4'd8},  // R8 xor
    '{3'd4, 3'd4, 8'b0000_1010, 32'hAAAAAAAA, 4'hA, 16'h0010, 1'b1, 4'd8},  // R8 and
    '{3'd4, 3'd5, 8'b0001_0110, 32'hBBBBBBBB, 4'hB, 16'h0070, 1'b1, 4'd8},  // R8 or
    '{3'd0, 3'd0, 8'b0000_1000, 32'hCCCCCCCC, 4'hC, 16'h0030, 1'b0, 4'd3},  // R3
    '{3'd5, 3'd0, 8'b0000_0011, 32'hDDDDDDDD, 4'hD, 16'h0000, 1'b1, 4'd9},  // R9
    '{3'd4, 3'd7, 8'b0000_0011, 32'hEEEEEEEE, 4'hE, 16'h0000, 1'b1, 4'd9},  // R9
    '{3'd1, 3'd0, 8'b0100_0000, 32'h22222222, 4'h2, 16'h0060, 1'b0, 4'd11}  // R11
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_phase = 1'b0;
  logic [7:0]   req_valid = '0;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_data = '0;
  logic [2:0]   policy = '0;
  logic [2:0]   red_op = '0;
  logic         err_clear = 1'b0;
  logic [3:0]   rd_addr = '0;
  logic [15:0]  rd_data;
  logic         conflict;
  logic         common_err;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] lfsr_m  = 16'hACE1;

  cw_resolver uut (
    .clk        (clk),
    .rst        (rst),
    .wr_phase   (wr_phase),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .policy     (policy),
    .red_op     (red_op),
    .err_clear  (err_clear),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .conflict   (conflict),
    .common_err (common_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] lfsr_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called and returning at a falling edge.
  task automatic write_step(input logic [2:0] pol, input logic [2:0] op, input logic [7:0] vld,
                            input logic [31:0] ad, input logic [127:0] dt, output logic conf);
    policy = pol; red_op = op; req_valid = vld; req_addr = ad; req_data = dt;
    wr_phase = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_phase = 1'b0;
    req_valid = '0;
    conf = conflict;
    lfsr_m = lfsr_next(lfsr_m);
  endtask

  task automatic read_word(input logic [3:0] a, output logic [15:0] v);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic        cf;
    logic [15:0] v;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(1, "conflict after reset", {15'd0, conflict}, 16'd0);
    check(1, "error after reset", {15'd0, common_err}, 16'd0);
    check(1, "rd_data after reset", rd_data, 16'd0);
    read_word(4'h9, v);
    check(1, "memory word after reset", v, 16'd0);

    // Table walk: R3 R4 R6 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      write_step(VECS[i].pol, VECS[i].op, VECS[i].vld, VECS[i].addr, DATA_A, cf);
      check(10, $sformatf("conflict row %0d", i), {15'd0, cf}, {15'd0, VECS[i].ec});
      read_word(VECS[i].ca, v);
      check(int'(VECS[i].rq), $sformatf("stored word row %0d", i), v, VECS[i].ev);
    end
    check(10, "conflict drops after idle edge", {15'd0, conflict}, 16'd0);

    // R5: common policy agreement
    write_step(3'd1, 3'd0, 8'hFF, 32'h11111111, {8{16'h1234}}, cf);
    check(5, "no error on agreement", {15'd0, common_err}, 16'd0);
    read_word(4'h1, v);
    check(5, "agreed value stored", v, 16'h1234);

    // R5: disagreement keeps old word, sets sticky error
    write_step(3'd1, 3'd0, 8'hFF, 32'h11111111,
               {{4{16'h1234}}, 16'h9999, {3{16'h1234}}}, cf);
    check(5, "error set on disagreement", {15'd0, common_err}, 16'd1);
    read_word(4'h1, v);
    check(5, "old word kept on disagreement", v, 16'h1234);
    repeat (3) @(negedge clk);
    check(5, "error sticky over idle cycles", {15'd0, common_err}, 16'd1);
    err_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_clear = 1'b0;
    check(5, "error cleared by pulse", {15'd0, common_err}, 16'd0);

    // R11: distinct addresses in one phase
    write_step(3'd1, 3'd0, 8'b0000_1111, 32'h00003210, DATA_A, cf);
    check(11, "no conflict for distinct addresses", {15'd0, cf}, 16'd0);
    read_word(4'h0, v);
    check(11, "word 0 from requester 0", v, 16'h0005);
    read_word(4'h3, v);
    check(11, "word 3 from requester 3", v, 16'h0030);

    // R2: rd_data holds during a write phase; no write without the phase
    rd_addr = 4'h0;
    write_step(3'd0, 3'd0, 8'h00, 32'h0, DATA_A, cf);
    check(2, "rd_data held across write phase", rd_data, 16'h0030);
    policy = 3'd0; req_valid = 8'hFF; req_addr = 32'h33333333; req_data = {8{16'hFFFF}};
    rd_addr = 4'h3;
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    read_word(4'h3, v);
    check(2, "no write outside write phase", v, 16'h0030);

    // R7: random choice among requesters 1, 4, 6
    for (int r = 0; r < 4; r++) begin
      logic [15:0] exp_v;
      case (lfsr_m % 16'd3)
        16'd0:   exp_v = 16'h0010;
        16'd1:   exp_v = 16'h0040;
        default: exp_v = 16'h0060;
      endcase
      write_step(3'd3, 3'd0, 8'b0101_0010, 32'hFFFFFFFF, DATA_A, cf);
      read_word(4'hF, v);
      check(7, $sformatf("random pick round %0d", r), v, exp_v);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule